// File: doc/BRIEF.md
# Positional-Priority Interrupt Aggregator

The block collects a parameterized number of interrupt request lines (1 to 32) and merges them into a single registered interrupt request. Each line is watched for a rising edge. An edge sets a sticky status bit, and the bit stays set until software writes a one to the matching bit of the acknowledge register. A per-line enable mask selects which captured bits count as pending. A one-bit master switch gates the merged output. When several pending bits are set, a vector register names the lowest-numbered one, so line 0 always wins.

Software reaches the registers through a simple register port. It has a 10-bit word address and a 32-bit data path. A read or write strobe whose address falls in the block's eight-word window gets a single-cycle acknowledge on the next clock. Read data is valid only during that acknowledge. The output can be wired into a line of another instance, so several blocks can be cascaded to serve more sources. The base address must be aligned to eight words.

Word offsets inside the window: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 vector, 7 master switch. Offsets 5 and 6 are unused.

Top module: `irq_aggr_top`

## Requirements
- R1: A read or write strobe whose address bits [9:3] equal those of BASE_ADDR raises `bus_ack` for exactly one cycle, on the clock after the strobe. A strobe outside the window raises no acknowledge. `bus_rdata` is zero whenever `bus_ack` is low.
- R2: A rising edge on `irq_in[i]` sets status bit i (offset 0). The bit stays set after the line falls. A line held high does not set the bit again after it has been acknowledged.
- R3: Writing a word to offset 3 clears each status bit whose data bit is 1 and leaves the others unchanged. If a rising edge arrives in the same cycle as the clear, the edge wins and the bit stays set. Offset 3 reads as zero.
- R4: Offset 2 holds the enable mask, which can be read and written. Bits at or above NUM_SRC read as zero. Offset 1 reads as status AND enable.
- R5: Offset 4 reads the index of the lowest-numbered pending bit, zero-extended. It reads 32'hFFFF_FFFF when no bit is pending.
- R6: Offset 7 bit 0 is the master switch. `irq_out` equals master AND (any pending bit). It is registered, so it changes one clock after the state it reflects.
- R7: After reset, status, enable and master are zero, and `irq_out` and `bus_ack` are low.
- R8: Writes to offsets 0, 1, 4, 5 and 6, and writes outside the window, change no register. Offsets 5 and 6 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | One-cycle access acknowledge |
| irq_in | input | NUM_SRC | Interrupt request lines |
| irq_out | output | 1 | Merged interrupt request |

## Verification
The bench goes after the cycle in which an acknowledge write and a fresh rising edge hit the same bit. A design that lets the clear win would silently lose that interrupt. It holds a line high across an acknowledge; a design that captured levels instead of edges would set the bit again at once. It checks that bit 0 beats every higher pending bit and that an empty set reads all ones, since a reversed scan or a zero default would send software to the wrong handler. It also aims strobes just outside the window and at the read-only offsets, where a loose address decode would acknowledge or corrupt the enable and master registers.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFS_W  = 3;
  localparam int unsigned IDX_W  = 5;

  typedef enum logic [OFS_W-1:0] {
    RS_STATUS = 3'd0,
    RS_PEND   = 3'd1,
    RS_EN     = 3'd2,
    RS_CLR    = 3'd3,
    RS_VEC    = 3'd4,
    RS_RSV5   = 3'd5,
    RS_RSV6   = 3'd6,
    RS_MASTER = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_in,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] status
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] rise;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
    assign rise[g] = req_in[g] & ~prev_q[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[g] <= 1'b0;
        status[g] <= 1'b0;
      end else begin
        prev_q[g] <= req_in[g];
        if (rise[g])
          status[g] <= 1'b1;
        else if (clr[g])
          status[g] <= 1'b0;
      end
    end
  end

  // R2: a set bit that was not cleared must still be set
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((($past(status) & ~$past(clr)) & ~status) == '0));

  // R3: an edge always lands, even against a clear
  a_r3_edge_wins: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((status & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0]              pend,
  output logic                            found,
  output logic [irq_aggr_pkg::IDX_W-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = irq_aggr_pkg::IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h040
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [NUM_SRC-1:0] status,
  input  logic [NUM_SRC-1:0] pend,
  input  logic               vec_found,
  input  logic [IDX_W-1:0]   vec_idx,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_ack,
  output logic [NUM_SRC-1:0] en_q,
  output logic               master_q,
  output logic [NUM_SRC-1:0] clr
);
  logic       hit;
  logic       sel;
  logic       wsel;
  reg_sel_e   ofs;
  logic [DATA_W-1:0] rd_mux;
  logic       unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign ofs  = reg_sel_e'(bus_addr[OFS_W-1:0]);
  assign hit  = (bus_addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
  assign sel  = (bus_rd | bus_wr) & hit & ~bus_ack;
  assign wsel = sel & bus_wr;
  assign clr  = (wsel && ofs == RS_CLR) ? bus_wdata[NUM_SRC-1:0] : '0;

  always_comb begin
    case (ofs)
      RS_STATUS: rd_mux = DATA_W'(status);
      RS_PEND:   rd_mux = DATA_W'(pend);
      RS_EN:     rd_mux = DATA_W'(en_q);
      RS_VEC:    rd_mux = vec_found ? DATA_W'(vec_idx) : '1;
      RS_MASTER: rd_mux = DATA_W'(master_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
      en_q      <= '0;
      master_q  <= 1'b0;
    end else begin
      bus_ack   <= sel;
      bus_rdata <= (sel && bus_rd && !bus_wr) ? rd_mux : '0;
      if (wsel && ofs == RS_EN)     en_q     <= bus_wdata[NUM_SRC-1:0];
      if (wsel && ofs == RS_MASTER) master_q <= bus_wdata[0];
    end
  end

  // R1: acknowledge lasts one cycle
  a_r1_ack_single: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  // R1: read data stays quiet outside an acknowledge
  a_r1_rdata_quiet: assert property (@(posedge clk) disable iff (rst)
    !bus_ack |-> (bus_rdata == '0));

  // R8: writes to read-only or unused offsets leave control state alone
  a_r8_ro_writes: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !(hit && (ofs == RS_EN || ofs == RS_MASTER)))
      |=> ($stable(en_q) && $stable(master_q)));
endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h040
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [9:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_ack,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic               irq_out
);
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clr;
  logic               master_q;
  logic               vec_found;
  logic [IDX_W-1:0]   vec_idx;
  logic               irq_q;

  irq_capture #(.NUM_SRC(NUM_SRC)) u_cap (
    .clk(clk), .rst(rst), .req_in(irq_in), .clr(clr), .status(status)
  );

  assign pend = status & en_q;

  irq_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .pend(pend), .found(vec_found), .idx(vec_idx)
  );

  irq_regs #(.NUM_SRC(NUM_SRC), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status(status),
    .pend(pend), .vec_found(vec_found), .vec_idx(vec_idx),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .en_q(en_q),
    .master_q(master_q), .clr(clr)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= master_q & (|pend);
  end
  assign irq_out = irq_q;

  // R6: master switch off forces the output low next cycle
  a_r6_master_gate: assert property (@(posedge clk) disable iff (rst)
    !master_q |=> !irq_q);

  // R5: vector names a pending bit with nothing pending below it
  a_r5_lowest: assert property (@(posedge clk) disable iff (rst)
    vec_found |-> ((((pend >> vec_idx) & NUM_SRC'(1)) == NUM_SRC'(1)) &&
                   ((pend & ((NUM_SRC'(1) << vec_idx) - NUM_SRC'(1))) == '0)));

  // R5: empty pending set reports no vector
  a_r5_none: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |-> !vec_found);

  // R7: reset leaves the output and acknowledge low
  a_r7_reset: assert property (@(posedge clk)
    rst |=> (!irq_q && !bus_ack && master_q == 1'b0));
endmodule

// File: tb/tb_irq_aggr_top.sv
`timescale 1ns/1ps
module tb_irq_aggr_top;
  localparam int unsigned N = 8;
  localparam logic [9:0] BASE = 10'h040;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic [N-1:0] irq_in = '0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [N-1:0] m_status = '0;
  logic [N-1:0] m_en = '0;
  logic [N-1:0] m_prev = '0;
  logic         m_master = 1'b0;

  irq_aggr_top #(.NUM_SRC(N), .BASE_ADDR(BASE)) dut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .irq_in(irq_in), .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] vec_of(input logic [N-1:0] p);
    for (int i = 0; i < N; i++)
      if (p[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_reg(input int ofs);
    case (ofs)
      0: return 32'(m_status);
      1: return 32'(m_status & m_en);
      2: return 32'(m_en);
      4: return vec_of(m_status & m_en);
      7: return 32'(m_master);
      default: return 32'h0;
    endcase
  endfunction

  // one bus access; optionally changes the request lines in the strobe cycle
  task automatic bus_op(input bit is_wr, input logic [9:0] a, input logic [31:0] d,
                        input bit chg, input logic [N-1:0] v,
                        output logic [31:0] rd, output logic acked);
    @(negedge clk);
    bus_rd = !is_wr; bus_wr = is_wr; bus_addr = a; bus_wdata = d;
    if (chg) irq_in = v;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    acked = bus_ack; rd = bus_rdata;
    @(negedge clk);
    chk("R1 ack one cycle", 32'(bus_ack), 32'h0);
    chk("R1 rdata idle zero", bus_rdata, 32'h0);
  endtask

  task automatic apply_write(input int ofs, input logic [31:0] d);
    case (ofs)
      2: m_en = d[N-1:0];
      3: m_status = m_status & ~d[N-1:0];
      7: m_master = d[0];
      default: ;
    endcase
  endtask

  task automatic check_irq();
    chk("R6 irq_out", 32'(irq_out), 32'(m_master && ((m_status & m_en) != '0)));
  endtask

  task automatic reg_write(input int ofs, input logic [31:0] d);
    logic [31:0] rd; logic ak;
    bus_op(1'b1, BASE + 10'(ofs), d, 1'b0, '0, rd, ak);
    chk("R1 write ack", 32'(ak), 32'h1);
    apply_write(ofs, d);
    check_irq();
  endtask

  task automatic reg_read(input int ofs, input string req);
    logic [31:0] rd; logic ak;
    bus_op(1'b0, BASE + 10'(ofs), 32'h0, 1'b0, '0, rd, ak);
    chk("R1 read ack", 32'(ak), 32'h1);
    chk(req, rd, exp_reg(ofs));
  endtask

  task automatic set_in(input logic [N-1:0] v);
    @(negedge clk);
    irq_in = v;
    m_status = m_status | (v & ~m_prev);
    m_prev = v;
    @(negedge clk);
    @(negedge clk);
    check_irq();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic ak;
    void'($urandom(32'h1357));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R7 reset state
    chk("R7 irq_out low", 32'(irq_out), 32'h0);
    chk("R7 ack low", 32'(bus_ack), 32'h0);
    for (int o = 0; o < 8; o++) reg_read(o, "R7 reset register");
    reg_read(4, "R5 empty vector all ones");

    // R1 / R8 misses just outside the window
    bus_op(1'b1, BASE + 10'd10, 32'hFF, 1'b0, '0, rd, ak);
    chk("R1 no ack outside window", 32'(ak), 32'h0);
    bus_op(1'b0, BASE - 10'd1, 32'h0, 1'b0, '0, rd, ak);
    chk("R1 no ack below window", 32'(ak), 32'h0);
    reg_read(2, "R8 miss left enable alone");

    // R2 edge capture and stickiness
    set_in(8'h08);
    set_in(8'h00);
    reg_read(0, "R2 sticky after fall");
    set_in(8'h20);
    reg_write(3, 32'h20);
    reg_read(0, "R2 held level not recaptured");
    reg_write(3, 32'h08);
    reg_read(0, "R3 clear only written bits");
    chk("R3 status empty", exp_reg(0), 32'h0);
    set_in(8'h00);

    // R3 collision: edge on bit1 with clear of bit1 in the same cycle
    set_in(8'h02);
    set_in(8'h00);
    bus_op(1'b1, BASE + 10'd3, 32'h02, 1'b1, 8'h02, rd, ak);
    m_status = (m_status & ~8'h02) | (8'h02 & ~m_prev);
    m_prev = 8'h02;
    reg_read(0, "R3 edge wins over clear");
    chk("R3 bit1 still set", exp_reg(0), 32'h2);
    reg_read(3, "R3 acknowledge reads zero");
    set_in(8'h00);
    reg_write(3, 32'hFF);

    // R4 enable mask width and pending view
    reg_write(2, 32'hFFFF_FFA5);
    reg_read(2, "R4 enable upper bits zero");
    set_in(8'h28);
    reg_read(1, "R4 pending is status and enable");

    // R5 priority
    reg_write(2, 32'hFF);
    reg_read(4, "R5 lowest pending index");
    set_in(8'h29);
    reg_read(4, "R5 bit0 wins");
    reg_write(2, 32'hFE);
    reg_read(4, "R5 masked bit skipped");

    // R6 master gating
    reg_write(7, 32'h0);
    chk("R6 master off forces low", 32'(irq_out), 32'h0);
    reg_write(7, 32'h1);
    chk("R6 master on raises irq", 32'(irq_out), 32'h1);
    reg_read(7, "R6 master readback");

    // R8 read-only and unused offsets
    reg_write(0, 32'h0);
    reg_write(1, 32'h0);
    reg_write(4, 32'h0);
    reg_write(5, 32'hFFFF_FFFF);
    reg_write(6, 32'hFFFF_FFFF);
    reg_read(0, "R8 status unchanged");
    reg_read(2, "R8 enable unchanged");
    reg_read(5, "R8 unused reads zero");
    reg_read(6, "R8 unused reads zero");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: set_in(N'($urandom));
        1: reg_write(2, $urandom);
        2: reg_write(3, $urandom);
        3: reg_write(7, $urandom);
        4: reg_write(int'($urandom % 8), $urandom);
        default: reg_read(int'($urandom % 8), "R5 random readback");
      endcase
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule